// File: doc/BRIEF.md
# UART Receive Status and Interrupt Unit

This block sits behind the serial shifter of an 8-bit UART receiver. Each time the shifter finishes a frame, it hands over the eight data bits and a flag that says the stop bit was sampled low. The block places the byte in a receive holding register and raises a data-ready flag. It also keeps the overrun, framing-error and line-break status bits, and it combines them into a single receiver interrupt. Software reads the status and the byte through a small read port. The port selects between the two registers, and its read strobes have side effects.

The block handles a frame that completes while the previous byte is still unread. The unread byte is treated as good and is never overwritten. The newest frame goes into a hidden shadow slot, along with its framing and break information, and no overrun is shown yet. When software reads the good byte, the shadow contents are moved into view. The status then shows data-ready together with overrun, plus framing error and break when the hidden frame carried them. Software must discard that presented byte. The error bits are cleared only by a status read followed by a data read.

Top module: `uart_rx_status`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00 and `rx_irq` is low.
- R2: A frame accepted while data-ready is clear can be read from the data register (`rd_sel`=1) on the next cycle, and status bit 0 (data-ready) is 1. Status layout: bit 0 data-ready, bit 1 overrun, bit 2 framing error, bit 3 break, bits 7..4 zero; `rd_sel`=0 selects status.
- R3: A data-register read strobe clears data-ready on the next cycle when no hidden overrun frame is waiting and no frame arrives in the same cycle.
- R4: `rx_irq` is high exactly when (data-ready and `ie_data`) or (`ie_err` and any of overrun, framing error, break); the data-ready source is gated only by `ie_data`.
- R5: A frame with its stop bit low sets the framing-error bit (bit 2).
- R6: A frame with all data bits 0 and its stop bit low is a break: it sets both the break bit (bit 3) and the framing-error bit.
- R7: A frame arriving while data-ready is set and no read strobe is present leaves the data register unchanged and does not change the visible status.
- R8: The data read of a byte that has a hidden overrun frame behind it makes the next cycle show data-ready and overrun, shows the newest hidden byte, and shows framing error and break if any hidden frame carried them.
- R9: A data read whose preceding read strobe was a status read clears overrun, framing error and break; a data read without a preceding status read leaves them set.
- R10: A frame that arrives in the same cycle as a data read, with no hidden frame waiting, is accepted as a fresh byte with no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frm_valid | input | 1 | One-cycle strobe: a frame has completed |
| frm_data | input | 8 | Data bits of the completed frame |
| frm_stop_low | input | 1 | Stop bit of the frame was sampled low |
| ie_data | input | 1 | Enables the data-ready interrupt source |
| ie_err | input | 1 | Enables the overrun, framing and break sources |
| rd_en | input | 1 | Read strobe; applies side effects at the clock edge |
| rd_sel | input | 1 | 0 selects status, 1 selects data |
| rd_data | output | 8 | Selected register contents (combinational) |
| rx_irq | output | 1 | Receiver interrupt |

## Verification
Single clean frames, each read back, show that a byte is captured and that the data read clears the ready flag. Frames with a low stop bit, with and without zero data, separate a framing error from a break. Back-to-back frames with no read between them produce an overrun. The bench checks that the good byte is kept and that the overrun stays hidden until the data read, and it also sends a break as the overrunning frame to show that the break is reported with it. Status-then-data read pairs are compared against plain data reads to show the clear rule, and a read strobe issued in the same cycle as a frame arrival shows that a freed register takes the frame without an overrun.

// File: rtl/uart_rx_status_pkg.sv
package uart_rx_status_pkg;
  localparam int DW = 8;
  localparam int BIT_RDY = 0;
  localparam int BIT_OVR = 1;
  localparam int BIT_FE  = 2;
  localparam int BIT_BRK = 3;

  typedef struct packed {
    logic rdy;
    logic ovr;
    logic fe;
    logic brk;
  } rx_flags_t;

  function automatic logic frame_is_break(input logic [DW-1:0] d, input logic stop_low);
    return stop_low && (d == '0);
  endfunction

  function automatic logic [DW-1:0] pack_status(input rx_flags_t f);
    logic [DW-1:0] s;
    s = '0;
    s[BIT_RDY] = f.rdy;
    s[BIT_OVR] = f.ovr;
    s[BIT_FE]  = f.fe;
    s[BIT_BRK] = f.brk;
    return s;
  endfunction

  function automatic logic irq_of(input rx_flags_t f, input logic en_d, input logic en_e);
    return (f.rdy && en_d) || (en_e && (f.ovr || f.fe || f.brk));
  endfunction
endpackage

// File: rtl/rxs_clear_seq.sv
module rxs_clear_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_read,
  input  logic data_read,
  output logic flag_clr
);
  logic armed_q;

  assign flag_clr = data_read && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (stat_read) armed_q <= 1'b1;
    else if (data_read) armed_q <= 1'b0;
  end

  // R9: a clear is issued only by a data read that follows a status read
  a_r9_clear_after_status: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr |-> armed_q && !stat_read);
endmodule

// File: rtl/rxs_hold.sv
module rxs_hold
  import uart_rx_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arrive,
  input  logic [DW-1:0] arr_data,
  input  logic          arr_stop_low,
  input  logic          data_read,
  input  logic          flag_clr,
  output logic [DW-1:0] data_q,
  output rx_flags_t     flags_q,
  output logic          accept_evt,
  output logic          ovr_evt,
  output logic          present_evt
);
  logic          pend_q, pend_fe_q, pend_brk_q;
  logic [DW-1:0] pend_data_q;
  logic          arr_brk, free_now;
  logic          base_ovr, base_fe, base_brk;

  assign arr_brk     = frame_is_break(arr_data, arr_stop_low);
  assign free_now    = data_read && !pend_q;
  assign accept_evt  = arrive && (!flags_q.rdy || free_now);
  assign ovr_evt     = arrive && !accept_evt;
  assign present_evt = data_read && pend_q;

  assign base_ovr = flag_clr ? 1'b0 : flags_q.ovr;
  assign base_fe  = flag_clr ? 1'b0 : flags_q.fe;
  assign base_brk = flag_clr ? 1'b0 : flags_q.brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      flags_q <= '0;
    end else if (present_evt) begin
      data_q      <= pend_data_q;
      flags_q.rdy <= 1'b1;
      flags_q.ovr <= 1'b1;
      flags_q.fe  <= base_fe  || pend_fe_q;
      flags_q.brk <= base_brk || pend_brk_q;
    end else if (accept_evt) begin
      data_q      <= arr_data;
      flags_q.rdy <= 1'b1;
      flags_q.ovr <= base_ovr;
      flags_q.fe  <= base_fe  || arr_stop_low;
      flags_q.brk <= base_brk || arr_brk;
    end else begin
      flags_q.rdy <= data_read ? 1'b0 : flags_q.rdy;
      flags_q.ovr <= base_ovr;
      flags_q.fe  <= base_fe;
      flags_q.brk <= base_brk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
      pend_fe_q   <= 1'b0;
      pend_brk_q  <= 1'b0;
    end else if (present_evt) begin
      pend_q      <= ovr_evt;
      pend_data_q <= ovr_evt ? arr_data : '0;
      pend_fe_q   <= ovr_evt && arr_stop_low;
      pend_brk_q  <= ovr_evt && arr_brk;
    end else if (ovr_evt) begin
      pend_q      <= 1'b1;
      pend_data_q <= arr_data;
      pend_fe_q   <= pend_fe_q || arr_stop_low;
      pend_brk_q  <= pend_brk_q || arr_brk;
    end
  end

  // R2: a frame into an empty register makes data ready
  a_r2_accept_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && !flags_q.rdy) |=> flags_q.rdy);
  // R3: an unqueued data read with no arrival frees the register
  a_r3_read_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (data_read && !pend_q && !arrive) |=> !flags_q.rdy);
  // R7: the valid byte is never overwritten by an overrunning frame
  a_r7_keep_valid_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (arrive && flags_q.rdy && !data_read) |=> $stable(data_q));
  // R8: the hidden frame is presented as ready with overrun
  a_r8_present_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    present_evt |=> (flags_q.rdy && flags_q.ovr));
  // R9: a clear with nothing new arriving leaves the error bits low
  a_r9_clear_drops_errors: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !pend_q && !arrive) |=> !(flags_q.ovr || flags_q.fe || flags_q.brk));
endmodule

// File: rtl/rxs_irq.sv
module rxs_irq
  import uart_rx_status_pkg::*;
(
  input  rx_flags_t flags,
  input  logic      en_data,
  input  logic      en_err,
  output logic      irq
);
  assign irq = irq_of(flags, en_data, en_err);

  // R4: with every source quiet the interrupt is low
  always_comb begin
    a_r4_quiet_no_irq: assert (!( !flags.rdy && !flags.ovr && !flags.fe && !flags.brk && irq));
  end
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_status_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_stop_low,
  input  logic          ie_data,
  input  logic          ie_err,
  input  logic          rd_en,
  input  logic          rd_sel,
  output logic [DW-1:0] rd_data,
  output logic          rx_irq
);
  logic          stat_read, data_read, flag_clr;
  logic [DW-1:0] data_q;
  rx_flags_t     flags_q;
  logic          accept_evt, ovr_evt, present_evt;

  assign stat_read = rd_en && !rd_sel;
  assign data_read = rd_en &&  rd_sel;

  rxs_clear_seq u_clr (
    .clk(clk), .rst_n(rst_n), .stat_read(stat_read),
    .data_read(data_read), .flag_clr(flag_clr)
  );

  rxs_hold u_hold (
    .clk(clk), .rst_n(rst_n), .arrive(frm_valid), .arr_data(frm_data),
    .arr_stop_low(frm_stop_low), .data_read(data_read), .flag_clr(flag_clr),
    .data_q(data_q), .flags_q(flags_q), .accept_evt(accept_evt),
    .ovr_evt(ovr_evt), .present_evt(present_evt)
  );

  rxs_irq u_irq (
    .flags(flags_q), .en_data(ie_data), .en_err(ie_err), .irq(rx_irq)
  );

  assign rd_data = rd_sel ? data_q : pack_status(flags_q);

  // R10: a frame with a simultaneous unqueued data read is taken, not overrun
  a_r10_read_frees_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && data_read && !present_evt) |-> (accept_evt && !ovr_evt));
  // R7: overrun is not made visible by the overrunning frame itself
  a_r7_overrun_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_evt && !present_evt && !flags_q.ovr && !flag_clr) |=> !flags_q.ovr);
endmodule

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/1ps
module sim_uart_rx_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frm_valid = 1'b0;
  logic [7:0] frm_data = 8'h00;
  logic       frm_stop_low = 1'b0;
  logic       ie_data = 1'b0;
  logic       ie_err = 1'b0;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       rx_irq;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  uart_rx_status u0 (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_data(frm_data),
    .frm_stop_low(frm_stop_low), .ie_data(ie_data), .ie_err(ie_err),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rx_irq(rx_irq)
  );

  // behavioural reference: visible byte, flags, and a queue of hidden frames
  int   m_byte, m_rdy, m_ovr, m_fe, m_brk, m_armed;
  int   q_byte[$];
  int   q_fe, q_brk;

  task automatic m_reset();
    m_byte = 0; m_rdy = 0; m_ovr = 0; m_fe = 0; m_brk = 0; m_armed = 0;
    q_byte.delete(); q_fe = 0; q_brk = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit dr, sr, clr, took_hidden;
      dr = rd_en && rd_sel;
      sr = rd_en && !rd_sel;
      clr = dr && (m_armed != 0);
      if (sr) m_armed = 1; else if (dr) m_armed = 0;
      if (clr) begin m_ovr = 0; m_fe = 0; m_brk = 0; end
      took_hidden = 0;
      if (dr) begin
        if (q_byte.size() > 0) begin
          m_byte = q_byte[$]; q_byte.delete();
          m_rdy = 1; m_ovr = 1;
          if (q_fe != 0) m_fe = 1;
          if (q_brk != 0) m_brk = 1;
          q_fe = 0; q_brk = 0; took_hidden = 1;
        end else m_rdy = 0;
      end
      if (frm_valid) begin
        if (m_rdy == 0) begin
          m_byte = frm_data; m_rdy = 1;
          if (frm_stop_low) m_fe = 1;
          if (frm_stop_low && frm_data == 8'h00) m_brk = 1;
        end else begin
          q_byte.push_back(frm_data);
          if (frm_stop_low) q_fe = 1;
          if (frm_stop_low && frm_data == 8'h00) q_brk = 1;
        end
      end
      if (took_hidden) ; // hidden frame already moved into view
    end
  end

  function automatic int m_status();
    return m_rdy | (m_ovr << 1) | (m_fe << 2) | (m_brk << 3);
  endfunction

  function automatic int m_irq();
    return ((m_rdy != 0) && ie_data) || (ie_err && (m_ovr || m_fe || m_brk));
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model (R4 interrupt, R2/R8 read port)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 model irq", int'(rx_irq), m_irq());
      chk("R8 model port", int'(rd_data), rd_sel ? m_byte : m_status());
    end
  end

  task automatic idle();
    @(negedge clk); #0.5;
    frm_valid = 0; rd_en = 0;
  endtask

  task automatic send(input logic [7:0] d, input logic sl);
    @(negedge clk); #0.5;
    frm_valid = 1; frm_data = d; frm_stop_low = sl; rd_en = 0;
    @(negedge clk); #0.5;
    frm_valid = 0;
  endtask

  task automatic rd(input logic sel);
    @(negedge clk); #0.5;
    rd_en = 1; rd_sel = sel; frm_valid = 0;
    @(negedge clk); #0.5;
    rd_en = 0;
  endtask

  task automatic peek(input string tag, input logic sel, input int exp);
    rd_sel = sel; #0.5;
    chk(tag, int'(rd_data), exp);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #12; rst_n = 1;
    idle();
    peek("R1 status", 0, 8'h00);
    peek("R1 data", 1, 8'h00);
    chk("R1 irq", int'(rx_irq), 0);

    ie_data = 1;
    send(8'h5A, 0);
    peek("R2 data", 1, 8'h5A);
    peek("R2 status", 0, 8'h01);
    chk("R4 irq ready", int'(rx_irq), 1);
    rd(1);
    peek("R3 status", 0, 8'h00);

    ie_data = 0;
    send(8'h33, 0);
    peek("R4 status", 0, 8'h01);
    chk("R4 irq masked", int'(rx_irq), 0);
    rd(1);

    ie_err = 1;
    send(8'h81, 1);
    peek("R5 status", 0, 8'h05);
    chk("R4 irq err", int'(rx_irq), 1);
    rd(0); rd(1);
    peek("R9 cleared", 0, 8'h00);

    send(8'h00, 1);
    peek("R6 status", 0, 8'h0D);
    rd(1);
    peek("R9 not cleared", 0, 8'h0C);
    rd(0); rd(1);
    peek("R9 cleared brk", 0, 8'h00);

    send(8'h11, 0);
    send(8'h00, 1);
    peek("R7 status", 0, 8'h01);
    peek("R7 data", 1, 8'h11);
    rd(1);
    peek("R8 status brk", 0, 8'h0F);
    peek("R8 data", 1, 8'h00);
    rd(0); rd(1);
    peek("R9 after ovr", 0, 8'h00);

    send(8'h22, 0);
    send(8'h44, 0);
    rd(1);
    peek("R8 status", 0, 8'h03);
    peek("R8 data2", 1, 8'h44);
    chk("R4 irq ovr", int'(rx_irq), 1);
    rd(0); rd(1);

    send(8'h66, 0);
    @(negedge clk); #0.5;
    rd_en = 1; rd_sel = 1; frm_valid = 1; frm_data = 8'h77; frm_stop_low = 0;
    @(negedge clk); #0.5;
    rd_en = 0; frm_valid = 0;
    peek("R10 status", 0, 8'h01);
    peek("R10 data", 1, 8'h77);

    idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule